// File: doc/BRIEF.md
# One-Time-Programmable Word Memory Model

This block is a synthesizable behavioural model of a word-wide memory whose bits can only be cleared, never set, once they leave the erased state. It is meant to stand in for such a device inside a larger simulation or emulation environment. Each cycle it works out an operating mode from five control inputs: an active-low select, an active-low output gate, an active-low program strobe, a flag saying the programming supply is raised, and a flag saying the identifier voltage is applied to the identifier address line. From that mode it decides whether the data bus is driven, and with what value.

The bidirectional data bus is split into an input word, an output word and an output-drive flag. Reads, verifies and identifier readouts are combinational from the address and the controls. A write is taken from the address and data sampled on the last clock edge of a low strobe pulse, and it is committed on the first edge that sees the strobe high again. The stored word becomes the old word ANDed with the new data. A separate wipe input sets every word back to all ones in one cycle, so a bench can reuse one instance across tests.

Top module: `otp_word_mem`

## Requirements
- R1: Normal read. With select low, gate low, strobe high, both flags clear, `dout_oe` is 1 and `dout` equals the stored word at `addr` in the same cycle.
- R2: Whenever `dout_oe` is 0, `dout` is all zeros. With select low and the supply flag clear, the bus is not driven if the gate is high, or if the strobe is low.
- R3: Standby. With select high and the supply flag clear, the bus is not driven, whatever the gate, strobe or identifier flag do.
- R4: Program. With select low and the supply flag set, a low strobe records `addr` and `din` on every clock edge. The write lands on the first edge that sees the strobe high with select still low and the supply flag still set, using the values from the last low edge. The bus is not driven while the strobe is low.
- R5: A write stores old AND new. A bit at 0 cannot return to 1 through programming. Writing all ones leaves the word unchanged.
- R6: Verify. With select low, gate low, strobe high and the supply flag set, the bus drives the stored word. With the gate high in the same state, the bus is not driven.
- R7: Inhibit. With select high and the supply flag set, the bus is not driven, and a strobe pulse writes nothing.
- R8: Identifier. With select low, gate low, strobe high, the supply flag clear and the identifier flag set, `dout` is 0x0020 when `addr` bit 0 is 0 and 0x008C when it is 1. Bits 15..8 are zero. With the gate high the bus is not driven.
- R9: Priority. Select high wins over everything. The supply flag then wins over the identifier flag, so verify returns stored data even when the identifier flag is set.
- R10: `wipe` high on a clock edge sets every word to 0xFFFF by that edge. It wins over a write that would land on the same edge.
- R11: Reset (active-low, synchronous) drops a pending write. A strobe that rises while reset is held, or on the first edge after reset, commits nothing.
- R12: If select rises or the supply flag drops before the strobe returns high, the pending write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock |
| rst_n | input | 1 | Synchronous active-low reset of the write path |
| sel_n | input | 1 | Active-low device select |
| gate_n | input | 1 | Active-low output gate |
| strobe_n | input | 1 | Active-low program strobe |
| vprog_hi | input | 1 | Programming supply raised |
| id_hv | input | 1 | Identifier voltage applied |
| wipe | input | 1 | Test-only erase of every word |
| addr | input | ADDR_W | Word address |
| din | input | 16 | Data to program |
| dout | output | 16 | Data driven onto the bus |
| dout_oe | output | 1 | Bus drive enable |

## Verification
The checker assumes the controls change only between clock edges and hold steady across each edge. It also assumes that `wipe` is used only as a test convenience, so a verify word read on two successive edges at one address may only lose ones unless a wipe came between them. The bench drives every input on the falling edge and reads outputs two nanoseconds later, so each input state is settled at the rising edge the properties sample. It pulses `wipe` only while the bus is idle.

// File: rtl/otp_mem_pkg.sv
// Shared definitions for the one-time-programmable word memory model.
// Assumes a 16-bit data word; identifier codes are 8 bits wide and zero-extended.
package otp_mem_pkg;

    typedef enum logic [2:0] {
        MODE_STANDBY,
        MODE_INHIBIT,
        MODE_PROGRAM,
        MODE_VERIFY,
        MODE_PROG_IDLE,
        MODE_IDENT,
        MODE_READ,
        MODE_FLOAT
    } otp_mode_e;

    localparam logic [7:0] ID_MAKER  = 8'h20;
    localparam logic [7:0] ID_DEVICE = 8'h8C;

endpackage

// File: rtl/otp_mode_decode.sv
// Combinational mode decoder.
// Priority: select high, then programming supply, then identifier flag, then
// plain read or float. Assumes all inputs are synchronous to the model clock.
module otp_mode_decode
    import otp_mem_pkg::*;
(
    input  logic      sel_n,
    input  logic      gate_n,
    input  logic      strobe_n,
    input  logic      vprog_hi,
    input  logic      id_hv,
    output otp_mode_e mode
);

    // Pick one operating mode from the control inputs, highest priority first.
    always_comb begin
        if (sel_n) begin
            mode = vprog_hi ? MODE_INHIBIT : MODE_STANDBY;
        end else if (vprog_hi) begin
            if (!strobe_n)      mode = MODE_PROGRAM;
            else if (!gate_n)   mode = MODE_VERIFY;
            else                mode = MODE_PROG_IDLE;
        end else if (!gate_n && strobe_n) begin
            mode = id_hv ? MODE_IDENT : MODE_READ;
        end else begin
            mode = MODE_FLOAT;
        end
    end

endmodule

// File: rtl/otp_word_array.sv
// Storage array with clear-only writes.
// A write is armed on every edge seen in program mode. The most recent address
// and data are held, and the write lands on the first edge where the strobe is
// high with select low and supply raised. The array itself is not reset,
// because contents are nonvolatile; the wipe input restores all ones.
module otp_word_array #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wipe,
    input  logic              prog_mode,
    input  logic              land_ok,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] rd_word
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];
    logic              armed;
    logic [ADDR_W-1:0] hold_addr;
    logic [DATA_W-1:0] hold_data;

    // Track whether the previous edge was inside a program pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= prog_mode;
    end

    // Keep the address and data of the latest low-strobe edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_addr <= '0;
            hold_data <= '1;
        end else if (prog_mode) begin
            hold_addr <= addr;
            hold_data <= din;
        end
    end

    // Wipe to all ones, or clear bits of the held word when the strobe returns high.
    always_ff @(posedge clk) begin
        if (wipe) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
        end else if (rst_n && armed && land_ok) begin
            cells[hold_addr] <= cells[hold_addr] & hold_data;
        end
    end

    assign rd_word = cells[addr];

endmodule

// File: rtl/otp_out_select.sv
// Output selector: chooses stored word, identifier code or nothing per mode.
// Assumes the undriven bus value is all zeros.
module otp_out_select
    import otp_mem_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  otp_mode_e         mode,
    input  logic [DATA_W-1:0] rd_word,
    input  logic              id_pick,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe
);

    localparam int PAD_W = DATA_W - 8;

    // Drive the bus only in read, verify and identifier modes.
    always_comb begin
        dout    = '0;
        dout_oe = 1'b0;
        unique case (mode)
            MODE_READ, MODE_VERIFY: begin
                dout    = rd_word;
                dout_oe = 1'b1;
            end
            MODE_IDENT: begin
                dout    = {{PAD_W{1'b0}}, (id_pick ? ID_DEVICE : ID_MAKER)};
                dout_oe = 1'b1;
            end
            default: begin
                dout    = '0;
                dout_oe = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/otp_word_mem.sv
// Top level of the one-time-programmable word memory model.
// Joins the mode decoder, the clear-only array and the output selector.
// Assumes synchronous control inputs and a 16-bit word.
module otp_word_mem
    import otp_mem_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              gate_n,
    input  logic              strobe_n,
    input  logic              vprog_hi,
    input  logic              id_hv,
    input  logic              wipe,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       din,
    output logic [15:0]       dout,
    output logic              dout_oe
);

    localparam int DATA_W = 16;

    otp_mode_e         mode;
    logic [DATA_W-1:0] rd_word;
    logic              land_ok;

    // A held write may land only while the device stays selected under raised supply.
    assign land_ok = strobe_n && !sel_n && vprog_hi;

    otp_mode_decode u_decode (
        .sel_n    (sel_n),
        .gate_n   (gate_n),
        .strobe_n (strobe_n),
        .vprog_hi (vprog_hi),
        .id_hv    (id_hv),
        .mode     (mode)
    );

    otp_word_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .wipe      (wipe),
        .prog_mode (mode == MODE_PROGRAM),
        .land_ok   (land_ok),
        .addr      (addr),
        .din       (din),
        .rd_word   (rd_word)
    );

    otp_out_select #(
        .DATA_W (DATA_W)
    ) u_out (
        .mode    (mode),
        .rd_word (rd_word),
        .id_pick (addr[0]),
        .dout    (dout),
        .dout_oe (dout_oe)
    );

endmodule

// File: rtl/otp_word_mem_chk.sv
// Port-level checker for otp_word_mem, attached by bind.
// Assumes inputs are stable around each rising clock edge.
module otp_word_mem_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_n,
    input logic              gate_n,
    input logic              strobe_n,
    input logic              vprog_hi,
    input logic              id_hv,
    input logic              wipe,
    input logic [ADDR_W-1:0] addr,
    input logic [15:0]       dout,
    input logic              dout_oe
);

    logic in_verify;
    assign in_verify = !sel_n && !gate_n && strobe_n && vprog_hi;

    // R3
    standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_n && !vprog_hi) |-> !dout_oe);

    // R2
    float_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_oe |-> (dout == 16'h0000));

    // R8
    ident_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && !gate_n && strobe_n && !vprog_hi && id_hv)
        |-> (dout_oe && dout == (addr[0] ? 16'h008C : 16'h0020)));

    // R4
    program_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && vprog_hi && !strobe_n) |-> !dout_oe);

    // R7
    inhibit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_n && vprog_hi) |-> !dout_oe);

    // R6
    verify_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_verify |-> dout_oe);

    // R5
    clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_verify && $past(in_verify) && $stable(addr) && !$past(wipe))
        |-> ((dout & ~$past(dout)) == 16'h0000));

endmodule

bind otp_word_mem otp_word_mem_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_n    (sel_n),
    .gate_n   (gate_n),
    .strobe_n (strobe_n),
    .vprog_hi (vprog_hi),
    .id_hv    (id_hv),
    .wipe     (wipe),
    .addr     (addr),
    .dout     (dout),
    .dout_oe  (dout_oe)
);

// File: tb/otp_word_mem_tb_top.sv
// Self-checking bench: a table of mode vectors, then directed write tests.
module otp_word_mem_tb_top;

    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel_n = 1'b1;
    logic          gate_n = 1'b1;
    logic          strobe_n = 1'b1;
    logic          vprog_hi = 1'b0;
    logic          id_hv = 1'b0;
    logic          wipe = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [15:0]   din = '0;
    logic [15:0]   dout;
    logic          dout_oe;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    otp_word_mem #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .gate_n(gate_n),
        .strobe_n(strobe_n), .vprog_hi(vprog_hi), .id_hv(id_hv), .wipe(wipe),
        .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe)
    );

    // Vector: sel_n gate_n strobe_n vprog id_hv | addr[5:0] | exp_oe | exp_dout | req
    localparam int NV = 14;
    localparam logic [31:0] VEC [NV] = '{
        {5'b00100, 6'd3, 1'b1, 16'h5A3C, 4'd1},  // R1 read programmed word
        {5'b00100, 6'd4, 1'b1, 16'hFFFF, 4'd1},  // R1 read erased word
        {5'b01100, 6'd3, 1'b0, 16'h0000, 4'd2},  // R2 gate high floats
        {5'b00000, 6'd3, 1'b0, 16'h0000, 4'd2},  // R2 strobe low without supply
        {5'b10100, 6'd3, 1'b0, 16'h0000, 4'd3},  // R3 standby, gate low
        {5'b11100, 6'd3, 1'b0, 16'h0000, 4'd3},  // R3 standby, gate high
        {5'b10110, 6'd3, 1'b0, 16'h0000, 4'd7},  // R7 inhibit floats
        {5'b00110, 6'd3, 1'b1, 16'h5A3C, 4'd6},  // R6 verify
        {5'b01110, 6'd3, 1'b0, 16'h0000, 4'd6},  // R6 supply raised, gate high
        {5'b00101, 6'd2, 1'b1, 16'h0020, 4'd8},  // R8 maker code
        {5'b00101, 6'd3, 1'b1, 16'h008C, 4'd8},  // R8 device code
        {5'b01101, 6'd3, 1'b0, 16'h0000, 4'd8},  // R8 gate high floats
        {5'b00111, 6'd3, 1'b1, 16'h5A3C, 4'd9},  // R9 supply beats identifier
        {5'b10101, 6'd3, 1'b0, 16'h0000, 4'd9}   // R9 select high beats identifier
    };

    task automatic check(input string req, input logic [16:0] got, input logic [16:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got oe=%0b data=%h, expected oe=%0b data=%h",
                     req, got[16], got[15:0], exp[16], exp[15:0]);
        end
    endtask

    task automatic go_idle();
        @(negedge clk);
        sel_n = 1'b1; gate_n = 1'b1; strobe_n = 1'b1; vprog_hi = 1'b0;
        id_hv = 1'b0; wipe = 1'b0;
    endtask

    // One-edge strobe pulse; the write lands on the edge after strobe rises.
    task automatic program_word(input logic [AW-1:0] a, input logic [15:0] d);
        @(negedge clk);
        sel_n = 1'b0; gate_n = 1'b1; vprog_hi = 1'b1; addr = a; din = d; strobe_n = 1'b0;
        @(negedge clk);
        strobe_n = 1'b1;
        @(posedge clk);
        go_idle();
    endtask

    task automatic read_check(input string req, input logic [AW-1:0] a, input logic [15:0] exp);
        @(negedge clk);
        sel_n = 1'b0; gate_n = 1'b0; strobe_n = 1'b1; vprog_hi = 1'b0; id_hv = 1'b0; addr = a;
        #2;
        check(req, {dout_oe, dout}, {1'b1, exp});
        go_idle();
    endtask

    task automatic wipe_all();
        @(negedge clk);
        wipe = 1'b1;
        @(negedge clk);
        wipe = 1'b0;
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got run still active, expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        #2;
        // R11 reset state with idle controls: bus not driven
        check("R11", {dout_oe, dout}, 17'h0_0000);
        rst_n = 1'b1;
        wipe_all();
        read_check("R10", 6'd3, 16'hFFFF);
        program_word(6'd3, 16'h5A3C);

        // Table walk over the mode combinations
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {sel_n, gate_n, strobe_n, vprog_hi, id_hv} = VEC[i][31:27];
            addr = VEC[i][26:21];
            #2;
            check($sformatf("R%0d", VEC[i][3:0]), {dout_oe, dout}, VEC[i][20:4]);
        end
        go_idle();

        // R5 writing all ones keeps the word; then AND with a new pattern
        program_word(6'd3, 16'hFFFF);
        read_check("R5", 6'd3, 16'h5A3C);
        program_word(6'd3, 16'h0FF0);
        read_check("R5", 6'd3, 16'h0A30);

        // R4 two-edge pulse: the last low edge supplies the data
        @(negedge clk);
        sel_n = 1'b0; vprog_hi = 1'b1; addr = 6'd5; din = 16'hF0F0; strobe_n = 1'b0;
        @(negedge clk);
        din = 16'h1234;
        @(negedge clk);
        strobe_n = 1'b1; din = 16'h0000;
        #2;
        // R4 write not landed until the strobe-high edge
        gate_n = 1'b0;
        #1;
        check("R4", {dout_oe, dout}, {1'b1, 16'hFFFF});
        @(negedge clk);
        #2;
        check("R4", {dout_oe, dout}, {1'b1, 16'h1234});
        go_idle();

        // R7 strobe pulse under inhibit writes nothing
        @(negedge clk);
        sel_n = 1'b1; vprog_hi = 1'b1; addr = 6'd3; din = 16'h0000; strobe_n = 1'b0;
        @(negedge clk);
        strobe_n = 1'b1;
        @(negedge clk);
        go_idle();
        read_check("R7", 6'd3, 16'h0A30);

        // R12 select rises before the strobe returns high
        @(negedge clk);
        sel_n = 1'b0; vprog_hi = 1'b1; addr = 6'd7; din = 16'h0000; strobe_n = 1'b0;
        @(negedge clk);
        sel_n = 1'b1; strobe_n = 1'b1;
        @(negedge clk);
        go_idle();
        read_check("R12", 6'd7, 16'hFFFF);

        // R12 supply drops before the strobe returns high
        @(negedge clk);
        sel_n = 1'b0; vprog_hi = 1'b1; addr = 6'd9; din = 16'h0000; strobe_n = 1'b0;
        @(negedge clk);
        vprog_hi = 1'b0; strobe_n = 1'b1;
        @(negedge clk);
        go_idle();
        read_check("R12", 6'd9, 16'hFFFF);

        // R11 reset during a pending write drops it
        @(negedge clk);
        sel_n = 1'b0; vprog_hi = 1'b1; addr = 6'd6; din = 16'h0000; strobe_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b0; strobe_n = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        go_idle();
        read_check("R11", 6'd6, 16'hFFFF);

        // R10 wipe on the same edge as a landing write wins
        @(negedge clk);
        sel_n = 1'b0; vprog_hi = 1'b1; addr = 6'd8; din = 16'h0000; strobe_n = 1'b0;
        @(negedge clk);
        strobe_n = 1'b1; wipe = 1'b1;
        @(negedge clk);
        go_idle();
        read_check("R10", 6'd8, 16'hFFFF);
        read_check("R10", 6'd3, 16'hFFFF);
        read_check("R10", 6'd5, 16'hFFFF);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule